// File: doc/BRIEF.md
# Pulse-Length Biphase Word Decoder

This block sits behind an envelope edge timer on a low-frequency tag receiver. Each measured pulse length arrives on a valid/ready stream. The block sorts each length into one of five classes: 1, 1.5, 2, 2.5 or 3 bit periods, each with a symmetric tolerance. It turns the classes into data bits with a small amount of state: the previous bit and a toggle flag. The bits are collected into 45-bit words, and each complete word is presented on a second valid/ready stream, already split into its fields, with an even-parity verdict.

Control logic pulses `blk_start` once a listen window has been found. The next pulse seeds a new word. A 3-period pulse is a listen window. It closes the current word and drops the bit emitted last. A word with exactly 45 kept bits is delivered, and the decoder is then ready to seed the next word. A shorter word ends the block. Both back-pressure rules follow from one choice: `pl_ready` is low for as long as a decoded word waits for `word_ready`. The upstream timer must therefore hold `pl_valid` and `pl_len` until `pl_ready` returns. A word, once offered, stays unchanged until it is taken.

Top module: `pulse_word_decoder`

## Requirements
- R1: A length within ±TOL (inclusive) of 2, 3, 4, 5 or 6 half periods is classed as 1, 1.5, 2, 2.5 or 3 periods. Any other length pulses `dec_err` for one cycle, abandons the word, and leaves the decoder idle until `blk_start`.
- R2: The seed pulse after `blk_start`, or after a delivered word, emits bits as follows. A 1.5 pulse emits 1. A 2 pulse emits 0 and sets the toggle flag. A 2.5 pulse emits 0 then 1.
- R3: After the seed, a 1-period pulse emits one more copy of the previous bit.
- R4: After the seed, a 1.5-period pulse depends on the toggle flag. With the flag set, it emits the previous bit and then its inverse, and clears the flag. With the flag clear, it emits the inverse of the previous bit and sets the flag.
- R5: After the seed, a 2-period pulse emits 0 then 1 and leaves the flag unchanged.
- R6: A 3-period pulse after the seed discards the bit emitted last. If 45 bits remain, they are offered as a word with `word_valid`, one cycle after the pulse is accepted.
- R7: A listen window that leaves fewer than 45 bits pulses `blk_end` for one cycle and idles the decoder. This includes a 3-period pulse used as the seed.
- R8: `dec_err` pulses in three cases: a pulse would raise the emitted count above 46, a 2.5-period pulse arrives after the seed, or a 1-period pulse arrives as the seed.
- R9: The first received bit is bit 44 of the word. The fields are laid out as follows:
  - Bytes: received MSB first, first byte on `word_data[31:24]`. Each byte is followed by its row parity bit, the first row on `word_rowpar[3]`.
  - Column parity: the next 8 bits, on `word_colpar[7:0]` with bit 7 first.
  - Stop bit: the last bit, on `word_stop`.
- R10: `word_perr` is 1 when any row bit differs from the XOR of its byte, or when `word_colpar` differs from the XOR of the four bytes.
- R11: While `word_valid` is high and `word_ready` is low, the word stays unchanged and `pl_ready` is low. The word is dropped in the cycle after `word_ready` is seen high.
- R12: After reset, `word_valid`, `blk_end` and `dec_err` are 0 and `pl_ready` is 1. Pulses accepted before `blk_start` produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Listen window found; next pulse seeds a word |
| pl_valid | input | 1 | Pulse length valid |
| pl_ready | output | 1 | Decoder can take a pulse length |
| pl_len | input | LEN_W | Pulse length in timer ticks |
| word_valid | output | 1 | Decoded word offered |
| word_ready | input | 1 | Word consumer accepts |
| word_data | output | 32 | Four data bytes, first byte high |
| word_rowpar | output | 4 | Row parity bits, first row high |
| word_colpar | output | 8 | Column parity bits |
| word_stop | output | 1 | Stop bit |
| word_perr | output | 1 | Parity disagreement in the offered word |
| blk_end | output | 1 | One-cycle pulse: short word, block finished |
| dec_err | output | 1 | One-cycle pulse: unusable pulse or overflow |

## Verification
Every result is registered once behind the edge that accepts the pulse causing it. `word_valid`, `blk_end` and `dec_err` therefore become visible in the cycle after that edge, and the word fields are valid together with `word_valid`. The bench drives each pulse for exactly one accepting edge and samples on the falling edge that follows. It counts word, block-end and error events between stimuli, so each result is tied to the pulse that produced it. For the stall test, the bench holds `word_ready` low and reads `word_valid`, `pl_ready` and the data over several falling edges before releasing it.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int WORD_BITS = 45;
  localparam int ROWS      = 4;

  typedef enum logic [2:0] {
    CL_NONE = 3'd0,
    CL_P10  = 3'd1,
    CL_P15  = 3'd2,
    CL_P20  = 3'd3,
    CL_P25  = 3'd4,
    CL_P30  = 3'd5
  } pclass_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_BITS = 2'd2
  } dstate_e;

  typedef struct packed {
    logic [ROWS-1:0][7:0] data;
    logic [ROWS-1:0]      rowp;
    logic [7:0]           colp;
    logic                 stop;
  } word_t;
endpackage

// File: rtl/pwd_classify.sv
module pwd_classify
  import pwd_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int HALF  = 32,
  parameter int TOL   = 8
) (
  input  logic [LEN_W-1:0] len,
  output pclass_e          cls
);
  localparam int NCLS = 5;

  logic [NCLS-1:0] hit;

  for (genvar k = 0; k < NCLS; k++) begin : g_band
    localparam int CTR = (k + 2) * HALF;
    localparam logic [LEN_W-1:0] LO = LEN_W'(CTR - TOL);
    localparam logic [LEN_W-1:0] HI = LEN_W'(CTR + TOL);
    assign hit[k] = (len >= LO) && (len <= HI);
  end

  always_comb begin
    cls = CL_NONE;
    for (int k = 0; k < NCLS; k++) begin
      if (hit[k]) cls = pclass_e'(3'(k + 1));
    end
  end
endmodule

// File: rtl/pwd_assemble.sv
module pwd_assemble
  import pwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 take,
  input  pclass_e              cls,
  output logic                 fin_word,
  output logic                 fin_eob,
  output logic                 fin_err,
  output logic [WORD_BITS-1:0] fin_bits
);
  localparam int SR_W  = WORD_BITS + 1;
  localparam int CNT_W = $clog2(SR_W + 3);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SR_W);

  dstate_e          st;
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic             flg;

  logic [1:0]       n_emit;
  logic             b_a, b_b, flg_nx;
  logic             lw, seed_end, bad;
  logic [CNT_W-1:0] cnt_sum;
  logic             ovf, act;

  always_comb begin
    n_emit   = 2'd0;
    b_a      = 1'b0;
    b_b      = 1'b0;
    flg_nx   = flg;
    lw       = 1'b0;
    seed_end = 1'b0;
    bad      = 1'b0;
    if (st == ST_SEED) begin
      unique case (cls)
        CL_P15:  begin n_emit = 2'd1; b_a = 1'b1; flg_nx = 1'b0; end
        CL_P20:  begin n_emit = 2'd1; b_a = 1'b0; flg_nx = 1'b1; end
        CL_P25:  begin n_emit = 2'd2; b_a = 1'b0; b_b = 1'b1; flg_nx = 1'b0; end
        CL_P30:  seed_end = 1'b1;
        default: bad = 1'b1;
      endcase
    end else begin
      unique case (cls)
        CL_P10:  begin n_emit = 2'd1; b_a = sr[0]; end
        CL_P15: begin
          if (flg) begin
            n_emit = 2'd2; b_a = sr[0]; b_b = ~sr[0]; flg_nx = 1'b0;
          end else begin
            n_emit = 2'd1; b_a = ~sr[0]; flg_nx = 1'b1;
          end
        end
        CL_P20:  begin n_emit = 2'd2; b_a = 1'b0; b_b = 1'b1; end
        CL_P30:  lw = 1'b1;
        default: bad = 1'b1;
      endcase
    end
  end

  assign cnt_sum  = cnt + CNT_W'(n_emit);
  assign ovf      = cnt_sum > FULL;
  assign act      = take && (st != ST_IDLE) && !start;
  assign fin_err  = act && (bad || ovf);
  assign fin_word = act && (st == ST_BITS) && lw && (cnt == FULL);
  assign fin_eob  = act && (((st == ST_SEED) && seed_end) ||
                            ((st == ST_BITS) && lw && (cnt < FULL)));
  assign fin_bits = sr[SR_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      sr  <= '0;
      cnt <= '0;
      flg <= 1'b0;
    end else if (start) begin
      st  <= ST_SEED;
      cnt <= '0;
      flg <= 1'b0;
    end else if (act) begin
      if (fin_err || fin_eob) begin
        st <= ST_IDLE;
      end else if (fin_word) begin
        st  <= ST_SEED;
        cnt <= '0;
        flg <= 1'b0;
      end else begin
        st  <= ST_BITS;
        cnt <= cnt_sum;
        flg <= flg_nx;
        if (n_emit == 2'd2) sr <= {sr[SR_W-3:0], b_a, b_b};
        else                sr <= {sr[SR_W-2:0], b_a};
      end
    end
  end
endmodule

// File: rtl/pwd_unpack.sv
module pwd_unpack
  import pwd_pkg::*;
(
  input  logic [WORD_BITS-1:0] raw,
  output word_t                w,
  output logic                 perr
);
  localparam int ROW_SPAN = 9;

  logic [ROWS-1:0] row_bad;
  logic [7:0]      col_x;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam int TOP = WORD_BITS - 1 - ROW_SPAN * i;
    assign w.data[ROWS-1-i] = raw[TOP -: 8];
    assign w.rowp[ROWS-1-i] = raw[TOP-8];
    assign row_bad[i]       = w.rowp[ROWS-1-i] ^ (^raw[TOP -: 8]);
  end

  assign w.colp = raw[8:1];
  assign w.stop = raw[0];

  always_comb begin
    col_x = 8'h00;
    for (int i = 0; i < ROWS; i++) col_x = col_x ^ w.data[i];
  end

  assign perr = (|row_bad) || (col_x != w.colp);
endmodule

// File: rtl/pulse_word_decoder.sv
module pulse_word_decoder
  import pwd_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int HALF  = 32,
  parameter int TOL   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [LEN_W-1:0] pl_len,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data,
  output logic [3:0]       word_rowpar,
  output logic [7:0]       word_colpar,
  output logic             word_stop,
  output logic             word_perr,
  output logic             blk_end,
  output logic             dec_err
);
  pclass_e              cls;
  logic                 take;
  logic                 fin_word, fin_eob, fin_err;
  logic [WORD_BITS-1:0] fin_bits;
  logic [WORD_BITS-1:0] word_q;
  word_t                wf;

  assign pl_ready = !word_valid;
  assign take     = pl_valid && pl_ready;

  pwd_classify #(.LEN_W(LEN_W), .HALF(HALF), .TOL(TOL)) u_cls (
    .len (pl_len),
    .cls (cls)
  );

  pwd_assemble u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (blk_start),
    .take     (take),
    .cls      (cls),
    .fin_word (fin_word),
    .fin_eob  (fin_eob),
    .fin_err  (fin_err),
    .fin_bits (fin_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_q     <= '0;
      blk_end    <= 1'b0;
      dec_err    <= 1'b0;
    end else begin
      blk_end <= fin_eob;
      dec_err <= fin_err;
      if (fin_word) begin
        word_valid <= 1'b1;
        word_q     <= fin_bits;
      end else if (word_ready) begin
        word_valid <= 1'b0;
      end
    end
  end

  pwd_unpack u_unp (
    .raw  (word_q),
    .w    (wf),
    .perr (word_perr)
  );

  assign word_data   = wf.data;
  assign word_rowpar = wf.rowp;
  assign word_colpar = wf.colp;
  assign word_stop   = wf.stop;
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pl_valid,
  input logic        pl_ready,
  input logic        word_valid,
  input logic        word_ready,
  input logic [31:0] word_data,
  input logic        blk_end,
  input logic        dec_err
);
  p_input_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !pl_ready);

  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  p_word_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(pl_valid && pl_ready));

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({$rose(word_valid), blk_end, dec_err}));

  p_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> !blk_end);

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> !dec_err);
endmodule

bind pulse_word_decoder pwd_checker u_pwd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pl_valid   (pl_valid),
  .pl_ready   (pl_ready),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .word_data  (word_data),
  .blk_end    (blk_end),
  .dec_err    (dec_err)
);

// File: tb/tb_pulse_word_decoder.sv
`timescale 1ns/1ps
module tb_pulse_word_decoder;
  localparam int LEN_W = 10;
  localparam int HALF  = 32;
  localparam int TOL   = 8;
  localparam int OC_WORD = 1, OC_EOB = 2, OC_ERR = 3;
  localparam int BAD_LEN = 73;

  // {expected outcome, seed code, 4 body codes, body count}; code = half periods, 0 = unusable
  localparam int NVEC = 9;
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd1, 3'd3, 3'd2, 3'd2, 3'd2, 3'd2, 6'd45},
    {2'd1, 3'd4, 3'd2, 3'd2, 3'd2, 3'd2, 6'd45},
    {2'd1, 3'd5, 3'd2, 3'd3, 3'd3, 3'd4, 6'd30},
    {2'd2, 3'd3, 3'd2, 3'd2, 3'd2, 3'd2, 6'd10},
    {2'd2, 3'd6, 3'd2, 3'd2, 3'd2, 3'd2, 6'd0},
    {2'd3, 3'd3, 3'd2, 3'd2, 3'd0, 3'd2, 6'd5},
    {2'd3, 3'd3, 3'd2, 3'd2, 3'd2, 3'd2, 6'd46},
    {2'd3, 3'd3, 3'd2, 3'd5, 3'd2, 3'd2, 6'd4},
    {2'd3, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 6'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             blk_start = 1'b0;
  logic             pl_valid = 1'b0;
  logic             pl_ready;
  logic [LEN_W-1:0] pl_len = '0;
  logic             word_valid;
  logic             word_ready = 1'b1;
  logic [31:0]      word_data;
  logic [3:0]       word_rowpar;
  logic [7:0]       word_colpar;
  logic             word_stop;
  logic             word_perr;
  logic             blk_end;
  logic             dec_err;

  int n_chk = 0;
  int n_fail = 0;
  int pidx = 0;
  int saw_word = 0, saw_eob = 0, saw_err = 0;
  logic [31:0] cap_data;
  logic [3:0]  cap_row;
  logic [7:0]  cap_col;
  logic        cap_stop, cap_perr;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_word_decoder #(.LEN_W(LEN_W), .HALF(HALF), .TOL(TOL)) dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_len(pl_len),
    .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .word_rowpar(word_rowpar), .word_colpar(word_colpar),
    .word_stop(word_stop), .word_perr(word_perr),
    .blk_end(blk_end), .dec_err(dec_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid && word_ready) begin
        saw_word++;
        cap_data = word_data; cap_row = word_rowpar; cap_col = word_colpar;
        cap_stop = word_stop; cap_perr = word_perr;
      end
      if (blk_end) saw_eob++;
      if (dec_err) saw_err++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int len);
    @(negedge clk);
    while (!pl_ready) @(negedge clk);
    pl_valid = 1'b1;
    pl_len   = LEN_W'(len);
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  function automatic int code_len(input int code);
    int off = (pidx % 3) * TOL - TOL;
    if (code == 0) return BAD_LEN;
    return code * HALF + off;
  endfunction

  task automatic send_code(input int code);
    int l = code_len(code);
    pidx++;
    send(l);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
  endtask

  // Reference decoder written from R2..R8
  task automatic model(input logic [22:0] v, output int oc, output logic [44:0] w);
    logic [45:0] sr = '0;
    int cnt = 0;
    bit prev = 0, flg = 0;
    int seed = int'(v[20:18]);
    int n = int'(v[5:0]);
    oc = 0;
    w  = '0;
    case (seed)
      3: begin sr = {sr[44:0], 1'b1}; cnt = 1; prev = 1; flg = 0; end
      4: begin sr = {sr[44:0], 1'b0}; cnt = 1; prev = 0; flg = 1; end
      5: begin sr = {sr[43:0], 2'b01}; cnt = 2; prev = 1; flg = 0; end
      6: begin oc = OC_EOB; return; end
      default: begin oc = OC_ERR; return; end
    endcase
    for (int i = 0; i < n; i++) begin
      int c = int'(v[17 - 3*(i%4) -: 3]);
      case (c)
        2: begin sr = {sr[44:0], prev}; cnt++; end
        3: begin
          if (flg) begin
            sr = {sr[43:0], prev, ~prev}; cnt += 2; prev = ~prev; flg = 0;
          end else begin
            sr = {sr[44:0], ~prev}; cnt++; prev = ~prev; flg = 1;
          end
        end
        4: begin sr = {sr[43:0], 2'b01}; cnt += 2; prev = 1; end
        default: begin oc = OC_ERR; return; end
      endcase
      if (cnt > 46) begin oc = OC_ERR; return; end
    end
    if (cnt == 46) begin oc = OC_WORD; w = sr[45:1]; end
    else oc = OC_EOB;
  endtask

  task automatic run_vec(input int idx);
    logic [22:0] v = VEC[idx];
    int oc;
    logic [44:0] w;
    logic [31:0] ed;
    logic [3:0]  er;
    logic [7:0]  ec;
    bit          ep;
    int n = int'(v[5:0]);
    model(v, oc, w);
    check(oc == int'(v[22:21]), "R6", $sformatf("vec%0d model outcome", idx), oc, v[22:21]);
    saw_word = 0; saw_eob = 0; saw_err = 0;
    pulse_start();
    send_code(int'(v[20:18]));
    for (int i = 0; i < n; i++) send_code(int'(v[17 - 3*(i%4) -: 3]));
    send_code(6);
    @(negedge clk); @(negedge clk);
    case (int'(v[22:21]))
      OC_WORD: check(saw_word == 1 && saw_eob == 0 && saw_err == 0, "R6",
                     $sformatf("vec%0d word outcome", idx), saw_word, 1);
      OC_EOB:  check(saw_eob == 1 && saw_word == 0 && saw_err == 0, "R7",
                     $sformatf("vec%0d block end", idx), saw_eob, 1);
      default: check(saw_err == 1 && saw_word == 0 && saw_eob == 0, "R8",
                     $sformatf("vec%0d decode error", idx), saw_err, 1);
    endcase
    if (int'(v[22:21]) == OC_WORD && saw_word == 1) begin
      ed = {w[44:37], w[35:28], w[26:19], w[17:10]};
      er = {w[36], w[27], w[18], w[9]};
      ec = w[8:1];
      ep = 1'b0;
      for (int r = 0; r < 4; r++) if (er[3-r] != ^ed[31-8*r -: 8]) ep = 1'b1;
      if (ec != (ed[31:24] ^ ed[23:16] ^ ed[15:8] ^ ed[7:0])) ep = 1'b1;
      check(cap_data == ed, "R9", $sformatf("vec%0d data (R2 R3 R4 R5)", idx), cap_data, ed);
      check({cap_row, cap_col, cap_stop} == {er, ec, w[0]}, "R9",
            $sformatf("vec%0d parity/stop fields", idx), {cap_row, cap_col, cap_stop}, {er, ec, w[0]});
      check(cap_perr == ep, "R10", $sformatf("vec%0d parity flag", idx), cap_perr, ep);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(word_valid == 0, "R12", "word_valid after reset", word_valid, 0);
    check(pl_ready == 1, "R12", "pl_ready after reset", pl_ready, 1);
    check(blk_end == 0 && dec_err == 0, "R12", "pulses after reset", {blk_end, dec_err}, 0);

    // R12 pulses before blk_start are ignored
    saw_word = 0; saw_eob = 0; saw_err = 0;
    send(96); send(BAD_LEN); send(192); send(64);
    @(negedge clk); @(negedge clk);
    check(saw_word + saw_eob + saw_err == 0, "R12", "no output while idle",
          saw_word + saw_eob + saw_err, 0);

    // Vector table: R1..R10
    for (int k = 0; k < NVEC; k++) run_vec(k);

    // R1 tolerance edge outside: 1.5-period centre + TOL + 1 is unusable
    saw_err = 0;
    pulse_start();
    send(96 + TOL + 1);
    @(negedge clk); @(negedge clk);
    check(saw_err == 1, "R1", "length just outside band", saw_err, 1);

    // R1 tolerance edge inside: 1.5-period centre - TOL seeds a word
    saw_err = 0; saw_eob = 0;
    pulse_start();
    send(96 - TOL);
    send(192);
    @(negedge clk); @(negedge clk);
    check(saw_eob == 1 && saw_err == 0, "R1", "length on band edge accepted", saw_eob, 1);

    // R11 back-pressure: all-zero word held while word_ready low
    word_ready = 1'b0;
    pulse_start();
    send(128);
    for (int i = 0; i < 45; i++) send(64);
    send(192);
    repeat (4) @(negedge clk);
    check(word_valid == 1, "R11", "word held while stalled", word_valid, 1);
    check(pl_ready == 0, "R11", "input stalled", pl_ready, 0);
    check(word_data == 32'h0 && word_perr == 0, "R11", "stalled word content",
          {word_data, word_perr}, 0);
    word_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(word_valid == 0, "R11", "word dropped after accept", word_valid, 0);
    check(pl_ready == 1, "R11", "input resumes", pl_ready, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule